// File: doc/BRIEF.md
# One-Hot Lexical Token Recognizer

This block turns a stream of 8-bit characters into a stream of 7-bit token codes for a parser further down the line. It recognises a small fixed lexicon: identifiers, unsigned decimal integers, eight single-character operators and whitespace. Anything else becomes an illegal-character token. Every automaton state has its own flip-flop. Each next-state bit is a sum of products over the current state bits and a few character-class lines that a separate decoder derives from the incoming byte.

At most one character is taken per clock, through a valid/ready handshake. A token is finished when its state meets a character that cannot extend it. In the same cycle that character is dispatched as if it came from the start state, so no cycle is lost at a token boundary. Finished tokens go into a small show-ahead queue that the parser drains with a pop strobe. When that queue is full the character input stalls, so no character is ever dropped. An end-of-input strobe flushes any half-built token and then adds an end marker.

Top module: `onehot_lexer`

## Requirements
- R1: While reset is held and after it is released, `tok_valid` is 0 and `in_ready` is 1.
- R2: A letter (A-Z, a-z) or underscore starts an identifier, and letters, digits and underscores extend it. The code 0x01 is queued when a character that cannot extend it is taken, or at end of input.
- R3: A run of digits 0-9 is a number with code 0x02. A letter or underscore right after a digit ends the number and starts an identifier in the same cycle.
- R4: Each of the eight characters `+ - * / = ( ) ;` is a token on its own, with code 0x10 plus its position in that list (0x10 for `+` through 0x17 for `;`). The code is queued when the next character or end of input is taken.
- R5: Space (0x20), tab (0x09), line feed (0x0A) and carriage return (0x0D) end any pending token and produce no token of their own.
- R6: Every other byte is a separate token with code 0x7E.
- R7: When `in_eoi` is accepted (`in_eoi` high, `in_valid` low, `in_ready` high), any pending token is queued first and then the end marker 0x7F. `in_ready` is 0 in the cycle after acceptance, until the marker has been queued.
- R8: `in_ready` is 0 whenever the token queue is full. No character is lost and no token is overwritten.
- R9: Exactly one automaton state bit is set after every clock.
- R10: Tokens leave in the order they were recognised. `tok_code` shows the oldest token while `tok_valid` is 1, and `tok_pop` removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A character is offered |
| in_char | input | 8 | Offered character |
| in_eoi | input | 1 | End-of-input strobe, used only when in_valid is low |
| in_ready | output | 1 | Character or end-of-input is taken this cycle if offered |
| tok_valid | output | 1 | Token queue holds at least one token |
| tok_code | output | 7 | Oldest queued token code |
| tok_pop | input | 1 | Remove the oldest token |

## Verification
The bench builds the block with a token queue only two entries deep. With such a shallow queue, a slow consumer quickly fills it and the character input stalls. The stall path, the end-marker wait while full and back-to-back boundaries such as a number running into an identifier are therefore reached within short streams. Directed strings cover each token class, the end-of-input flush and an empty stream. Random strings mixing every character class are played with random feed gaps and random pops, and each popped code is compared with a token list that a bench scanner computes from the same string.

// File: rtl/lexer_pkg.sv
package lexer_pkg;
  localparam int TOK_W = 7;
  localparam int CH_W  = 8;

  // One-hot state bit positions
  localparam int ST_START = 0;
  localparam int ST_IDENT = 1;
  localparam int ST_NUM   = 2;
  localparam int ST_OP    = 3;
  localparam int ST_ILL   = 4;
  localparam int ST_ENDM  = 5;
  localparam int N_ST     = 6;

  localparam logic [TOK_W-1:0] TK_IDENT   = TOK_W'(8'h01);
  localparam logic [TOK_W-1:0] TK_NUM     = TOK_W'(8'h02);
  localparam logic [TOK_W-1:0] TK_OP_BASE = TOK_W'(8'h10);
  localparam logic [TOK_W-1:0] TK_ILLEGAL = TOK_W'(8'h7E);
  localparam logic [TOK_W-1:0] TK_END     = TOK_W'(8'h7F);

  typedef struct packed {
    logic       letter;
    logic       digit;
    logic       under;
    logic       ws;
    logic       op;
    logic       other;
    logic [2:0] op_idx;
  } cclass_t;

  function automatic logic in_span(input logic [CH_W-1:0] c,
                                   input logic [CH_W-1:0] lo,
                                   input logic [CH_W-1:0] hi);
    return (c >= lo) && (c <= hi);
  endfunction

  // Operator slot; the slot order fixes the emitted code
  function automatic logic [3:0] op_slot(input logic [CH_W-1:0] c);
    case (c)
      8'h2B:   return 4'h8; // +
      8'h2D:   return 4'h9; // -
      8'h2A:   return 4'hA; // *
      8'h2F:   return 4'hB; // /
      8'h3D:   return 4'hC; // =
      8'h28:   return 4'hD; // (
      8'h29:   return 4'hE; // )
      8'h3B:   return 4'hF; // ;
      default: return 4'h0; // bit 3 clear: not an operator
    endcase
  endfunction

  function automatic logic [TOK_W-1:0] op_code(input logic [2:0] idx);
    return TK_OP_BASE + TOK_W'(idx);
  endfunction

  function automatic logic [TOK_W-1:0] pend_code(input logic [N_ST-1:0] st,
                                                 input logic [2:0] opi);
    logic [TOK_W-1:0] code;
    code = TK_END;
    if (st[ST_IDENT]) code = TK_IDENT;
    if (st[ST_NUM])   code = TK_NUM;
    if (st[ST_OP])    code = op_code(opi);
    if (st[ST_ILL])   code = TK_ILLEGAL;
    return code;
  endfunction
endpackage

// File: rtl/lex_char_class.sv
module lex_char_class
  import lexer_pkg::*;
(
  input  logic [CH_W-1:0] ch,
  output cclass_t         cls
);
  logic [3:0] slot;

  always_comb begin
    slot       = op_slot(ch);
    cls.letter = in_span(ch, 8'h41, 8'h5A) || in_span(ch, 8'h61, 8'h7A);
    cls.digit  = in_span(ch, 8'h30, 8'h39);
    cls.under  = (ch == 8'h5F);
    cls.ws     = (ch == 8'h20) || (ch == 8'h09) || (ch == 8'h0A) || (ch == 8'h0D);
    cls.op     = slot[3];
    cls.op_idx = slot[2:0];
    cls.other  = !(cls.letter || cls.digit || cls.under || cls.ws || cls.op);
  end
endmodule

// File: rtl/lex_tok_fifo.sv
module lex_tok_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         valid,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign valid   = (cnt_q != '0);
  assign do_push = push && !full;
  assign do_pop  = pop && valid;
  assign dout    = mem[rd_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= bump(wr_q);
      if (do_pop)  rd_q <= bump(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/lex_dfa.sv
module lex_dfa
  import lexer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cclass_t          cls,
  input  logic             consume_char,
  input  logic             consume_eoi,
  input  logic             fifo_full,
  output logic [N_ST-1:0]  state_q,
  output logic             push,
  output logic [TOK_W-1:0] push_code
);
  logic [N_ST-1:0] state_d;
  logic [2:0]      op_q;
  logic            pending, id_ext, nm_ext, extend, restart;

  // One flip-flop per automaton state
  for (genvar i = 0; i < N_ST; i++) begin : g_state
    localparam logic RST_VAL = (i == ST_START);
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= RST_VAL;
      else        bit_q <= state_d[i];
    end
    assign state_q[i] = bit_q;
  end

  always_comb begin
    pending = state_q[ST_IDENT] | state_q[ST_NUM] | state_q[ST_OP] | state_q[ST_ILL];
    id_ext  = state_q[ST_IDENT] & (cls.letter | cls.digit | cls.under);
    nm_ext  = state_q[ST_NUM] & cls.digit;
    extend  = id_ext | nm_ext;
    restart = state_q[ST_START] | (pending & ~extend);

    state_d   = state_q;
    push      = 1'b0;
    push_code = pend_code(state_q, op_q);

    if (consume_char) begin
      state_d           = '0;
      state_d[ST_IDENT] = id_ext | (restart & (cls.letter | cls.under));
      state_d[ST_NUM]   = nm_ext | (restart & cls.digit);
      state_d[ST_OP]    = restart & cls.op;
      state_d[ST_ILL]   = restart & cls.other;
      state_d[ST_START] = restart & cls.ws;
      push              = pending & ~extend;
    end else if (consume_eoi) begin
      state_d          = '0;
      state_d[ST_ENDM] = 1'b1;
      push             = pending;
    end else if (state_q[ST_ENDM]) begin
      push              = ~fifo_full;
      push_code         = TK_END;
      state_d[ST_ENDM]  = fifo_full;
      state_d[ST_START] = ~fifo_full;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) op_q <= '0;
    else if (consume_char && restart && cls.op) op_q <= cls.op_idx;
  end
endmodule

// File: rtl/onehot_lexer.sv
module onehot_lexer
  import lexer_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [CH_W-1:0]  in_char,
  input  logic             in_eoi,
  output logic             in_ready,
  output logic             tok_valid,
  output logic [TOK_W-1:0] tok_code,
  input  logic             tok_pop
);
  cclass_t          cls;
  logic [N_ST-1:0]  state_q;
  logic             push, fifo_full, consume_char, consume_eoi, cls_ws;
  logic [TOK_W-1:0] push_code;

  assign in_ready     = ~fifo_full & ~state_q[ST_ENDM];
  assign consume_char = in_valid & in_ready;
  assign consume_eoi  = in_eoi & ~in_valid & in_ready;
  assign cls_ws       = cls.ws;

  lex_char_class u_class (
    .ch  (in_char),
    .cls (cls)
  );

  lex_dfa u_dfa (
    .clk          (clk),
    .rst_n        (rst_n),
    .cls          (cls),
    .consume_char (consume_char),
    .consume_eoi  (consume_eoi),
    .fifo_full    (fifo_full),
    .state_q      (state_q),
    .push         (push),
    .push_code    (push_code)
  );

  lex_tok_fifo #(.DEPTH(FIFO_DEPTH), .W(TOK_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (push_code),
    .pop   (tok_pop),
    .dout  (tok_code),
    .valid (tok_valid),
    .full  (fifo_full)
  );
endmodule

// File: rtl/lexer_checker.sv
module lexer_checker
  import lexer_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [N_ST-1:0] state_q,
  input logic            in_ready,
  input logic            fifo_full,
  input logic            push,
  input logic            consume_char,
  input logic            consume_eoi,
  input logic            cls_ws
);
  assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_q) == 1)
    else $error("state vector not one-hot");

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !push)
    else $error("write into full token queue");

  assert_stall_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !in_ready)
    else $error("input ready while queue full");

  assert_ws_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (consume_char && cls_ws && state_q[ST_START]) |-> !push)
    else $error("whitespace produced a token");

  assert_eoi_enters_marker_R7: assert property (@(posedge clk) disable iff (!rst_n)
    consume_eoi |=> state_q[ST_ENDM])
    else $error("end of input did not schedule marker");

  assert_marker_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q[ST_ENDM] && !fifo_full) |=> state_q[ST_START])
    else $error("marker state did not return to start");

  assert_marker_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state_q[ST_ENDM] |-> !in_ready)
    else $error("input ready during marker write");
endmodule

bind onehot_lexer lexer_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .state_q      (state_q),
  .in_ready     (in_ready),
  .fifo_full    (fifo_full),
  .push         (push),
  .consume_char (consume_char),
  .consume_eoi  (consume_eoi),
  .cls_ws       (cls_ws)
);

// File: tb/onehot_lexer_bench.sv
module onehot_lexer_bench;
  localparam int DEPTH = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_eoi = 1'b0;
  logic       tok_pop = 1'b0;
  logic [7:0] in_char = 8'h00;
  logic       in_ready, tok_valid;
  logic [6:0] tok_code;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] str [0:255];
  int slen = 0;
  logic [6:0] exq [$];

  always #10 clk = ~clk;

  onehot_lexer #(.FIFO_DEPTH(DEPTH)) u_onehot_lexer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_char(in_char),
    .in_eoi(in_eoi), .in_ready(in_ready), .tok_valid(tok_valid),
    .tok_code(tok_code), .tok_pop(tok_pop)
  );

  function automatic bit is_alpha(input logic [7:0] c);
    return (c >= "a" && c <= "z") || (c >= "A" && c <= "Z") || c == "_";
  endfunction
  function automatic bit is_dig(input logic [7:0] c);
    return c >= "0" && c <= "9";
  endfunction
  function automatic bit is_blank(input logic [7:0] c);
    return c == 8'h20 || c == 8'h09 || c == 8'h0A || c == 8'h0D;
  endfunction
  function automatic int op_pos(input logic [7:0] c);
    string ops = "+-*/=();";
    for (int k = 0; k < ops.len(); k++) if (ops[k] == c) return k;
    return -1;
  endfunction
  function automatic string tag_of(input logic [6:0] code);
    if (code == 7'h01) return "R2";
    if (code == 7'h02) return "R3";
    if (code == 7'h7E) return "R6";
    if (code == 7'h7F) return "R7";
    return "R4";
  endfunction

  task automatic check(input string req, input string what, input bit ok,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic load(input string s);
    slen = s.len();
    for (int k = 0; k < slen; k++) str[k] = s[k];
  endtask

  // Bench scanner: expected token list from the requirements
  task automatic build_expect();
    int i = 0;
    exq.delete();
    while (i < slen) begin
      if (is_alpha(str[i])) begin
        while (i < slen && (is_alpha(str[i]) || is_dig(str[i]))) i++;
        exq.push_back(7'h01);
      end else if (is_dig(str[i])) begin
        while (i < slen && is_dig(str[i])) i++;
        exq.push_back(7'h02);
      end else if (is_blank(str[i])) begin
        i++;
      end else if (op_pos(str[i]) >= 0) begin
        exq.push_back(7'h10 + 7'(op_pos(str[i])));
        i++;
      end else begin
        exq.push_back(7'h7E);
        i++;
      end
    end
    exq.push_back(7'h7F);
  endtask

  task automatic run(input string name, input int pop_pct, input int feed_pct,
                     output int stalls);
    int idx = 0;
    bit sent = 0, eoi_pend = 0, done = 0;
    int cyc = 0;
    stalls = 0;
    build_expect();
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (eoi_pend) begin
        check("R7", {name, " ready low after end strobe"}, in_ready == 1'b0,
              int'(in_ready), 0);
        eoi_pend = 0;
      end
      if (tok_valid && int'($urandom % 100) < pop_pct) begin
        if (exq.size() == 0) begin
          check("R10", {name, " unexpected token"}, 1'b0, int'(tok_code), 0);
        end else begin
          logic [6:0] h;
          h = exq.pop_front();
          check(tag_of(h), {name, " token"}, tok_code == h, int'(tok_code), int'(h));
        end
        tok_pop = 1'b1;
      end else begin
        tok_pop = 1'b0;
      end
      in_valid = 1'b0;
      in_eoi   = 1'b0;
      if (!in_ready) stalls++;
      if (!sent && in_ready && int'($urandom % 100) < feed_pct) begin
        if (idx < slen) begin
          in_valid = 1'b1;
          in_char  = str[idx];
          idx++;
        end else begin
          in_eoi   = 1'b1;
          sent     = 1;
          eoi_pend = 1;
        end
      end
      done = sent && !eoi_pend && exq.size() == 0 && !tok_valid && in_ready;
    end
    tok_pop  = 1'b0;
    in_valid = 1'b0;
    in_eoi   = 1'b0;
    check("R10", {name, " stream drained"}, done, exq.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int st;
    string pool;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1", "valid in reset", tok_valid == 1'b0, int'(tok_valid), 0);
    check("R1", "ready in reset", in_ready == 1'b1, int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "valid after reset", tok_valid == 1'b0, int'(tok_valid), 0);
    check("R1", "ready after reset", in_ready == 1'b1, int'(in_ready), 1);

    load("alpha_1 42x+;");  run("R2 R3 R4 mixed", 100, 100, st);
    load("9a 007b _z9");    run("R3 number into ident", 100, 100, st);
    load("+-*/=();");       run("R4 all operators", 100, 100, st);
    load(" \t\n\r  ");      run("R5 blanks only", 100, 100, st);
    load("a#@ 1$");         run("R6 illegal bytes", 100, 100, st);
    load("");               run("R7 R9 empty stream", 100, 100, st);
    load("abc");            run("R7 flush ident", 100, 100, st);
    load("x=1;y=22+z*(3)/w;");
    run("R8 slow consumer", 10, 100, st);
    check("R8", "stall observed", st > 0, st, 1);

    pool = "ab_Zq09 +-*/=();\t#@";
    for (int r = 0; r < 10; r++) begin
      slen = 30;
      for (int k = 0; k < slen; k++) str[k] = pool[$urandom % pool.len()];
      run("R9 R10 random", 60, 70, st);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule